// File: doc/BRIEF.md
# Register-Based LIFO Stack with Full and Empty Flags

This block is a last-in, first-out store of 64 bytes held in flip-flops. A 6-bit pointer selects one of the 64 slots. Two flags report whether the stack is empty or holds 64 items. A client pulses a push strobe with a byte to store, or a pop strobe to get the most recent byte back. The popped byte is registered and stays on its output until the next pop that the block accepts.

The pointer moves up before a write and down after a read. Both flags come from the pointer returning to zero. The first item therefore lands in slot 1 and the sixty-fourth lands in slot 0. A push against a full stack or a pop against an empty stack changes nothing and raises a one-cycle error pulse. Push and pop in the same cycle cancel each other.

Top module: `rstack_top`

## Requirements
- R1: After reset, empty is 1, full is 0, errPulse is 0 and popData is 0.
- R2: An accepted push moves the pointer up by one and then writes pushData into the slot it now selects. The bytes come back in reverse order of pushing.
- R3: After an accepted push, empty is 0. full becomes 1 only when the pointer has wrapped to 0.
- R4: An accepted pop copies the slot under the pointer into popData and then moves the pointer down by one. popData shows the value one clock after the strobe.
- R5: After an accepted pop, full is 0. empty becomes 1 only when the pointer has returned to 0.
- R6: A push while full is 1 leaves the pointer, flags and contents unchanged, and errPulse is 1 for the following cycle.
- R7: A pop while empty is 1 leaves the pointer, flags and popData unchanged, and errPulse is 1 for the following cycle.
- R8: pushReq and popReq high in the same cycle change nothing and raise no error.
- R9: popData keeps its value in every cycle without an accepted pop.
- R10: The stack holds exactly 64 items. The 64th push is accepted and sets full, and the 65th is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| pushReq | input | 1 | Push strobe |
| popReq | input | 1 | Pop strobe |
| pushData | input | 8 | Byte to store on push |
| popData | output | 8 | Last popped byte |
| full | output | 1 | Stack holds 64 items |
| empty | output | 1 | Stack holds no items |
| errPulse | output | 1 | One-cycle pulse after a rejected push or pop |

## Verification
On every cycle, assertions check several rules: the two flags are never both set, the pointer steps by exactly one on each accepted operation, the flag updates follow push and pop, rejected and simultaneous requests leave the pointer stable, and popData is held when there is no pop. Some behaviour only the bench scenarios can show. These are the LIFO ordering of real data across a full fill and drain, the 64-item capacity with the last item in slot 0, and the fact that a rejected push does not corrupt stored data.

// File: rtl/rstack_pkg.sv
package rstack_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic doPush;
    logic doPop;
  } stackCtl_t;
endpackage

// File: rtl/rstack_ctrl.sv
module rstack_ctrl #(
  parameter int ADDR_W = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   pushReq,
  input  logic                   popReq,
  output rstack_pkg::stackCtl_t  ctl,
  output logic [ADDR_W-1:0]      slotSel,
  output logic                   full,
  output logic                   empty,
  output logic                   errPulse
);
  logic [ADDR_W-1:0] sp, spInc, spDec;
  logic wantPush, wantPop;

  always_comb begin
    wantPush   = pushReq && !popReq;
    wantPop    = popReq && !pushReq;
    ctl.doPush = wantPush && !full;
    ctl.doPop  = wantPop && !empty;
    spInc      = sp + ADDR_W'(1);
    spDec      = sp - ADDR_W'(1);
    slotSel    = ctl.doPush ? spInc : sp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sp       <= '0;
      full     <= 1'b0;
      empty    <= 1'b1;
      errPulse <= 1'b0;
    end else begin
      errPulse <= (wantPush && full) || (wantPop && empty);
      if (ctl.doPush) begin
        sp    <= spInc;
        full  <= (spInc == '0);
        empty <= 1'b0;
      end else if (ctl.doPop) begin
        sp    <= spDec;
        empty <= (spDec == '0);
        full  <= 1'b0;
      end
    end
  end

  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(full && empty));
  assert_push_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doPush |=> (sp == $past(sp) + ADDR_W'(1)) && !empty);
  assert_pop_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doPop |=> (sp == $past(sp) - ADDR_W'(1)));
  assert_pop_clears_full_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.doPop |=> !full);
  assert_reject_push_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && !popReq && full) |=> $stable(sp) && full && errPulse);
  assert_reject_pop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !pushReq && empty) |=> $stable(sp) && empty && errPulse);
  assert_both_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && popReq) |=> $stable(sp) && !errPulse);
endmodule

// File: rtl/rstack_dpath.sv
module rstack_dpath #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  rstack_pkg::stackCtl_t ctl,
  input  logic [ADDR_W-1:0]     slotSel,
  input  logic [DATA_W-1:0]     pushData,
  output logic [DATA_W-1:0]     popData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (ctl.doPush) slots[slotSel] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          popData <= '0;
    else if (ctl.doPop) popData <= slots[slotSel];
  end

  assert_hold_output_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.doPop |=> $stable(popData));
  assert_no_dual_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.doPush && ctl.doPop));
endmodule

// File: rtl/rstack_top.sv
module rstack_top #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushReq,
  input  logic              popReq,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] popData,
  output logic              full,
  output logic              empty,
  output logic              errPulse
);
  rstack_pkg::stackCtl_t ctl;
  logic [ADDR_W-1:0] slotSel;

  rstack_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .popReq(popReq),
    .ctl(ctl), .slotSel(slotSel), .full(full), .empty(empty),
    .errPulse(errPulse)
  );

  rstack_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .slotSel(slotSel),
    .pushData(pushData), .popData(popData)
  );
endmodule

// File: tb/test_rstack_top.sv
`timescale 1ns/1ps
module test_rstack_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushReq = 1'b0, popReq = 1'b0;
  logic [7:0] pushData = '0;
  logic [7:0] popData;
  logic full, empty, errPulse;
  int nChecks = 0, nFails = 0;

  always #2.5 clk = ~clk;

  rstack_top i_rstack_top (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .popReq(popReq),
    .pushData(pushData), .popData(popData), .full(full), .empty(empty),
    .errPulse(errPulse)
  );

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one cycle, sample just after the edge
  task automatic step(logic pu, logic po, logic [7:0] d);
    @(negedge clk);
    pushReq = pu; popReq = po; pushData = d;
    @(posedge clk); #1;
    pushReq = 1'b0; popReq = 1'b0;
  endtask

  task automatic tReset();
    chk(empty == 1'b1, "R1 empty", int'(empty), 1);
    chk(full == 1'b0, "R1 full", int'(full), 0);
    chk(errPulse == 1'b0, "R1 err", int'(errPulse), 0);
    chk(popData == 8'd0, "R1 popData", int'(popData), 0);
  endtask

  task automatic tShortLifo();
    step(1, 0, 8'hA1);
    chk(!empty && !full, "R3 flags after first push", int'({full, empty}), 0);
    step(1, 0, 8'hB2);
    step(1, 0, 8'hC3);
    step(0, 0, 8'h00);
    chk(popData == 8'd0, "R9 hold before pop", int'(popData), 0);
    step(0, 1, 8'h00);
    chk(popData == 8'hC3, "R4 pop 1", int'(popData), 8'hC3);
    step(0, 1, 8'h00);
    chk(popData == 8'hB2, "R2 pop 2", int'(popData), 8'hB2);
    step(0, 0, 8'h00);
    step(0, 0, 8'h00);
    chk(popData == 8'hB2, "R9 hold idle", int'(popData), 8'hB2);
    step(0, 1, 8'h00);
    chk(popData == 8'hA1, "R2 pop 3", int'(popData), 8'hA1);
    chk(empty && !full, "R5 empty after drain", int'({full, empty}), 1);
  endtask

  task automatic tFillAndReject();
    int badFlag = 0;
    for (int i = 0; i < 64; i++) begin
      step(1, 0, pat(i));
      if (i < 63 && (full || empty)) badFlag++;
    end
    chk(badFlag == 0, "R3 flags while filling", badFlag, 0);
    chk(full && !empty, "R10 full after 64", int'({full, empty}), 2);
    step(1, 0, 8'hEE);
    chk(errPulse == 1'b1, "R6 err on push full", int'(errPulse), 1);
    chk(full == 1'b1, "R6 still full", int'(full), 1);
    step(0, 0, 8'h00);
    chk(errPulse == 1'b0, "R6 err one cycle", int'(errPulse), 0);
  endtask

  task automatic tDrain();
    int bad = 0;
    step(0, 1, 8'h00);
    chk(popData == pat(63), "R10 64th item from slot 0", int'(popData), int'(pat(63)));
    chk(!full, "R5 full cleared", int'(full), 0);
    for (int i = 62; i >= 0; i--) begin
      step(0, 1, 8'h00);
      if (popData != pat(i)) begin
        bad++;
        $display("FAIL R2 item %0d actual=%0d expected=%0d", i, popData, pat(i));
      end
      if (i > 0 && empty) bad++;
    end
    chk(bad == 0, "R2 drain order", bad, 0);
    chk(empty && !full, "R5 empty after 64 pops", int'({full, empty}), 1);
  endtask

  task automatic tRejectPop();
    step(0, 1, 8'h00);
    chk(errPulse == 1'b1, "R7 err on pop empty", int'(errPulse), 1);
    chk(popData == pat(0), "R7 popData kept", int'(popData), int'(pat(0)));
    chk(empty == 1'b1, "R7 still empty", int'(empty), 1);
    step(0, 0, 8'h00);
    chk(errPulse == 1'b0, "R7 err one cycle", int'(errPulse), 0);
  endtask

  task automatic tSimultaneous();
    step(1, 1, 8'h55);
    chk(empty && !errPulse, "R8 both on empty", int'({errPulse, empty}), 1);
    step(1, 0, 8'h66);
    step(1, 1, 8'h77);
    chk(!empty && !errPulse, "R8 both with one item", int'({errPulse, empty}), 0);
    chk(popData == pat(0), "R8 popData unchanged", int'(popData), int'(pat(0)));
    step(0, 1, 8'h00);
    chk(popData == 8'h66, "R8 stored item intact", int'(popData), 8'h66);
    chk(empty == 1'b1, "R5 empty again", int'(empty), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    tReset();
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    tReset();
    tShortLifo();
    tFillAndReject();
    tDrain();
    tRejectPop();
    tSimultaneous();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #100000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule